// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds wall-clock time and calendar date as eight packed-BCD bytes and advances them by one second each time a one-cycle enable pulse arrives from an external divider. It handles minute, hour, day, month, year and century carries, and it knows the length of every month. It applies a simple divisible-by-four leap rule. Hours can be kept in 24-hour form, or in 12-hour form with a PM flag.

A host uses a byte-wide register port. To read, it pulses the snapshot strobe. This freezes a copy of the counters, and the host can then read that copy one byte at a time while the live counters keep running. To write, the host sends byte writes. The first write of a session copies the live time into a shadow buffer, and each written byte replaces one byte of that buffer. A commit strobe then moves the whole buffer into the counters, or an abort strobe throws it away.

After a power-up reset, counting is frozen and a power-loss flag is raised. Both stay that way until the first commit.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Moving from 59 to 00 carries one into the next field up.
- R2: When hour byte bit 7 is 1 (24-hour form), bits 5:0 hold BCD 00 to 23. Moving from 23 to 00 advances the date, and the hour byte then reads 0x80.
- R3: When hour byte bit 7 is 0 (12-hour form), bits 4:0 hold BCD 1 to 12 and bit 5 is the PM flag. The sequence runs 11 to 12 with the PM flag toggling, then 12 to 1. Going from 11 PM to 12 AM also advances the date.
- R4: The date wraps to 01 after the last day of its month. That last day is 30 for April, June, September and November, 31 for the other months except February, and 28 or 29 for February.
- R5: February has 29 days whenever the two-digit year is divisible by four, and that includes year 00.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00, and at that moment a century byte of 0x19 becomes 0x20.
- R7: The day-of-week byte steps through 0 to 6 and then back to 0, once for every date change.
- R8: A snapshot strobe copies the live counters into a read latch, and rd_data always returns the latched byte. The address map is: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century.
- R9: The first write of a session loads the live time into the buffer before the written byte is applied. A commit copies the whole buffer into the counters. Bytes that were never written keep the value they had when the buffer was loaded.
- R10: An abort ends the session without changing the counters. A commit given while no session is open has no effect.
- R11: A commit takes priority over a tick in the same cycle. The committed time first advances on the next tick.
- R12: Reset sets the time to 00:00:00 in 24-hour form, date 01, month 01, year 00, century 20, day 0, and raises power_lost. While power_lost is high, ticks are ignored. The first commit clears power_lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also models a power-up after total power loss |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_addr | input | 3 | Byte address for both reads and writes |
| wr_data | input | 8 | Byte to write |
| wr_en | input | 1 | Write strobe for the shadow buffer |
| snap_en | input | 1 | Snapshot strobe for the read latch |
| commit_en | input | 1 | Commit strobe: buffer to counters |
| abort_en | input | 1 | Abort strobe: discard the buffer |
| rd_data | output | 8 | Byte of the read latch at reg_addr |
| power_lost | output | 1 | High from reset until the first commit |

## Verification
The counters can only be seen through snapshots, so a wrong carry or a wrong month length shows up in the first snapshot taken after the tick that crosses that boundary. The bench therefore sets the counters one second before each boundary, applies exactly one tick, and checks all eight bytes, which also catches corruption of neighbouring fields. A buffer that was loaded at the wrong moment, or a lost priority between commit and tick, shows up one snapshot after the commit as a wrong seconds or minutes byte. A read latch that still follows the live counters shows up as soon as ticks are applied between the snapshot and the read.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELD_CNT = 8;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = $clog2(FIELD_CNT);
    localparam int VEC_W     = FIELD_CNT * BYTE_W;

    localparam int HOUR_MODE24_BIT = 7;
    localparam int HOUR_PM_BIT     = 5;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_YEAR  = 3'd5,
        FLD_DOW   = 3'd6,
        FLD_CENT  = 3'd7
    } field_e;

    // Byte i of the packed vector is the field at address i.
    typedef struct packed {
        logic [BYTE_W-1:0] cent;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        cent:  8'h20,
        dow:   8'h00,
        year:  8'h00,
        month: 8'h01,
        date:  8'h01,
        hour:  8'h80,
        min:   8'h00,
        sec:   8'h00
    };

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] == 4'd9)
            return {b[7:4] + 4'd1, 4'd0};
        else
            return {b[7:4], b[3:0] + 4'd1};
    endfunction

    // Divisible by four: even tens need units 0/4/8, odd tens need 2/6.
    function automatic logic bcd_is_leap(input logic [7:0] y);
        if (!y[4])
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic       sec_wrap;
    logic       min_wrap;
    logic       day_carry;
    logic       mon_carry;
    logic       year_carry;
    logic [7:0] h_tmp;
    logic [7:0] h12;
    logic       pm_n;

    always_comb begin
        nxt        = cur;
        day_carry  = 1'b0;
        mon_carry  = 1'b0;
        year_carry = 1'b0;
        h_tmp      = 8'h00;
        h12        = {3'b000, cur.hour[4:0]};
        pm_n       = cur.hour[HOUR_PM_BIT];

        sec_wrap = (cur.sec == 8'h59);
        min_wrap = sec_wrap && (cur.min == 8'h59);
        nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);

        if (sec_wrap)
            nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);

        if (min_wrap) begin
            if (cur.hour[HOUR_MODE24_BIT]) begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour  = 8'h80;
                    day_carry = 1'b1;
                end else begin
                    h_tmp    = bcd_inc({2'b00, cur.hour[5:0]});
                    nxt.hour = {1'b1, 1'b0, h_tmp[5:0]};
                end
            end else begin
                if (h12 == 8'h11) begin
                    h_tmp     = 8'h12;
                    pm_n      = ~cur.hour[HOUR_PM_BIT];
                    day_carry = cur.hour[HOUR_PM_BIT];
                end else if (h12 == 8'h12) begin
                    h_tmp = 8'h01;
                end else begin
                    h_tmp = bcd_inc(h12);
                end
                nxt.hour = {1'b0, cur.hour[6], pm_n, h_tmp[4:0]};
            end
        end

        if (day_carry) begin
            nxt.dow = (cur.dow[2:0] == 3'd6) ? 8'h00 : {5'b0, cur.dow[2:0] + 3'd1};
            if (cur.date == bcd_last_day(cur.month, cur.year)) begin
                nxt.date  = 8'h01;
                mon_carry = 1'b1;
            end else begin
                nxt.date = bcd_inc(cur.date);
            end
        end

        if (mon_carry) begin
            if (cur.month == 8'h12) begin
                nxt.month  = 8'h01;
                year_carry = 1'b1;
            end else begin
                nxt.month = bcd_inc(cur.month);
            end
        end

        if (year_carry) begin
            if (cur.year == 8'h99) begin
                nxt.year = 8'h00;
                if (cur.cent == 8'h19)
                    nxt.cent = 8'h20;
            end else begin
                nxt.year = bcd_inc(cur.year);
            end
        end
    end
endmodule

// File: rtl/rtc_shadow_buf.sv
module rtc_shadow_buf
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_t              live,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit_en,
    input  logic              abort_en,
    output cal_t              buf_q,
    output logic              commit_apply
);
    logic             active;
    logic [VEC_W-1:0] base_v;
    logic [VEC_W-1:0] merged_v;

    assign base_v       = active ? buf_q : live;
    assign commit_apply = commit_en && active;

    generate
        for (genvar i = 0; i < FIELD_CNT; i++) begin : g_byte
            assign merged_v[BYTE_W*i +: BYTE_W] =
                (wr_addr == ADDR_W'(i)) ? wr_data : base_v[BYTE_W*i +: BYTE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            buf_q  <= CAL_RESET;
        end else if (commit_en || abort_en) begin
            active <= 1'b0;
        end else if (wr_en) begin
            active <= 1'b1;
            buf_q  <= cal_t'(merged_v);
        end
    end

    // R9: a first write opens the session and loads untouched bytes from live
    assert_session_load_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !active && !commit_en && !abort_en && wr_addr != FLD_SEC)
            |=> (active && buf_q.sec == $past(live.sec)));

    // R10: abort closes the session
    assert_abort_close_R10: assert property (@(posedge clk) disable iff (rst)
        abort_en |=> !active);
endmodule

// File: rtl/rtc_live_counters.sv
module rtc_live_counters
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic commit_apply,
    input  cal_t commit_val,
    output cal_t live,
    output logic power_lost
);
    cal_t nxt;

    rtc_next_time u_next (
        .cur (live),
        .nxt (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live       <= CAL_RESET;
            power_lost <= 1'b1;
        end else if (commit_apply) begin
            live       <= commit_val;
            power_lost <= 1'b0;
        end else if (sec_tick && !power_lost) begin
            live <= nxt;
        end
    end

    // R12: frozen while the power-loss flag is up
    assert_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (power_lost && !commit_apply) |=> $stable(live));

    // R12: first commit clears the flag
    assert_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
        commit_apply |=> !power_lost);

    // R9 / R11: commit loads the buffer regardless of a same-cycle tick
    assert_commit_load_R11: assert property (@(posedge clk) disable iff (rst)
        commit_apply |=> (live == $past(commit_val)));

    // R1: seconds wrap on a tick
    assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !power_lost && !commit_apply && live.sec == 8'h59)
            |=> (live.sec == 8'h00));

    // R6: without a commit the century can only move to 20
    assert_century_R6: assert property (@(posedge clk) disable iff (rst)
        !commit_apply |=> (live.cent == $past(live.cent) || live.cent == 8'h20));

    // R7: day of week stays in range when counting
    assert_dow_range_R7: assert property (@(posedge clk) disable iff (rst)
        (!commit_apply && live.dow <= 8'h06) |=> (live.dow <= 8'h06));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [2:0] reg_addr,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    input  logic       snap_en,
    input  logic       commit_en,
    input  logic       abort_en,
    output logic [7:0] rd_data,
    output logic       power_lost
);
    cal_t             live;
    cal_t             shadow;
    cal_t             snap_q;
    logic             commit_apply;
    logic [VEC_W-1:0] snap_v;

    rtc_shadow_buf u_buf (
        .clk          (clk),
        .rst          (rst),
        .live         (live),
        .wr_en        (wr_en),
        .wr_addr      (reg_addr),
        .wr_data      (wr_data),
        .commit_en    (commit_en),
        .abort_en     (abort_en),
        .buf_q        (shadow),
        .commit_apply (commit_apply)
    );

    rtc_live_counters u_cnt (
        .clk          (clk),
        .rst          (rst),
        .sec_tick     (sec_tick),
        .commit_apply (commit_apply),
        .commit_val   (shadow),
        .live         (live),
        .power_lost   (power_lost)
    );

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= CAL_RESET;
        else if (snap_en)
            snap_q <= live;
    end

    assign snap_v  = snap_q;
    assign rd_data = snap_v[{reg_addr, 3'b000} +: BYTE_W];

    // R8: latch holds between snapshots
    assert_snap_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !snap_en |=> $stable(snap_q));

    // R8: snapshot captures the live counters
    assert_snap_take_R8: assert property (@(posedge clk) disable iff (rst)
        snap_en |=> (snap_q == $past(live)));
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic       snap_en = 1'b0;
    logic       commit_en = 1'b0;
    logic       abort_en = 1'b0;
    logic [7:0] rd_data;
    logic       power_lost;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_flag;
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    rtc_bcd_calendar dut (
        .clk        (clk),
        .rst        (rst),
        .sec_tick   (sec_tick),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .snap_en    (snap_en),
        .commit_en  (commit_en),
        .abort_en   (abort_en),
        .rd_data    (rd_data),
        .power_lost (power_lost)
    );

    always #10 clk = ~clk;

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_flag ? {7'b0, power_lost} : rd_data;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic push_exp(input bit flag, input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.is_flag = flag; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic do_tick(input int n);
        @(posedge clk); #1 sec_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 sec_tick = 1'b0;
    endtask

    task automatic do_snap();
        @(posedge clk); #1 snap_en = 1'b1;
        @(posedge clk); #1 snap_en = 1'b0;
    endtask

    task automatic do_commit();
        @(posedge clk); #1 commit_en = 1'b1;
        @(posedge clk); #1 commit_en = 1'b0;
    endtask

    task automatic do_abort();
        @(posedge clk); #1 abort_en = 1'b1;
        @(posedge clk); #1 abort_en = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1 wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, dt, mo, y, dw, c);
        do_write(3'd0, s);  do_write(3'd1, m);  do_write(3'd2, h);  do_write(3'd3, dt);
        do_write(3'd4, mo); do_write(3'd5, y);  do_write(3'd6, dw); do_write(3'd7, c);
        do_commit();
    endtask

    task automatic check_time(input logic [7:0] s, m, h, dt, mo, y, dw, c, input string tag);
        do_snap();
        push_exp(1'b0, 3'd0, s,  tag); push_exp(1'b0, 3'd1, m,  tag);
        push_exp(1'b0, 3'd2, h,  tag); push_exp(1'b0, 3'd3, dt, tag);
        push_exp(1'b0, 3'd4, mo, tag); push_exp(1'b0, 3'd5, y,  tag);
        push_exp(1'b0, 3'd6, dw, tag); push_exp(1'b0, 3'd7, c,  tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state and frozen counting
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20, "R12 reset");
        push_exp(1'b1, 3'd0, 8'h01, "R12 flag set");
        do_tick(5);
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20, "R12 frozen");

        // R9 single byte commit, R12 flag clears
        do_write(3'd0, 8'h58);
        do_commit();
        push_exp(1'b1, 3'd0, 8'h00, "R12 flag clear");
        check_time(8'h58, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20, "R9 commit");
        do_tick(1);
        check_time(8'h59, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20, "R1 count");
        do_tick(1);
        check_time(8'h00, 8'h01, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20, "R1 carry");

        // R2 R4 R7 day rollover, non-leap February
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h06, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 8'h00, 8'h20, "R2 R4 R7 feb");

        // R5 leap year 24 and year 00
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h02, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, 8'h03, 8'h20, "R5 leap 24");
        set_time(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h03, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h24, 8'h04, 8'h20, "R5 leap end");
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 8'h01, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h00, 8'h02, 8'h20, "R5 year 00");

        // R6 year and century rollover
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h05, 8'h19);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h06, 8'h20, "R6 century");

        // R4 thirty-day month
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 8'h00, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h23, 8'h01, 8'h20, "R4 april");

        // R3 12-hour sequence
        set_time(8'h59, 8'h59, 8'h11, 8'h10, 8'h06, 8'h23, 8'h00, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h32, 8'h10, 8'h06, 8'h23, 8'h00, 8'h20, "R3 11am-12pm");
        set_time(8'h59, 8'h59, 8'h32, 8'h10, 8'h06, 8'h23, 8'h00, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h21, 8'h10, 8'h06, 8'h23, 8'h00, 8'h20, "R3 12pm-1pm");
        set_time(8'h59, 8'h59, 8'h31, 8'h10, 8'h06, 8'h23, 8'h00, 8'h20);
        do_tick(1);
        check_time(8'h00, 8'h00, 8'h12, 8'h11, 8'h06, 8'h23, 8'h01, 8'h20, "R3 11pm-12am");

        // R8 latch holds while counting continues
        set_time(8'h00, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20);
        do_snap();
        do_tick(3);
        push_exp(1'b0, 3'd0, 8'h00, "R8 latch hold");
        check_time(8'h03, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20, "R8 new snap");

        // R10 abort discards, stray commit ignored
        do_write(3'd0, 8'h30);
        do_abort();
        do_commit();
        check_time(8'h03, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20, "R10 abort");

        // R11 commit beats a same-cycle tick
        do_write(3'd0, 8'h10);
        @(posedge clk); #1 commit_en = 1'b1; sec_tick = 1'b1;
        @(posedge clk); #1 commit_en = 1'b0; sec_tick = 1'b0;
        check_time(8'h10, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20, "R11 priority");
        do_tick(1);
        check_time(8'h11, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20, "R11 next tick");

        // R9 unwritten bytes keep loaded values though live keeps ticking
        do_write(3'd1, 8'h05);
        do_tick(3);
        do_commit();
        check_time(8'h11, 8'h05, 8'hA0, 8'h01, 8'h01, 8'h23, 8'h00, 8'h20, "R9 loaded bytes");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule